// File: doc/BRIEF.md
# Legacy keyboard port emulation controller

This block lets emulation software stand in for an old-style keyboard controller. It watches host I/O writes aimed at the keyboard data port (60h) and the command port (64h). It follows the gate-A20 command sequence in hardware, so that a repeated A20 setting costs no software entry. It also records rising edges on the two interrupt lines of an external keyboard controller. Whenever software has to act, it raises a one-cycle system-management event.

The block also drives the two legacy interrupt outputs, keyboard (IRQ1) and auxiliary (IRQ12), from three controller status flags: output full, auxiliary output full and input full. Software reads and writes one 32-bit control word at offset 100h. Through that word it enables emulation, arms interrupt generation, asks for an event when a pending character has been taken, holds the current A20 level and clears the latched edge flags.

Top module: `kbd_legacy_trap`

## Requirements
- R1: After reset, the control word reads 00000000h and irq1, irq12 and smi_evt are all low.
- R2: Bits 31:9 of the control word always read 0. Any offset other than 100h reads 0. Software writes to bit 5 (A20 armed) and bit 1 (emulation interrupt) do not change them.
- R3: Software writes set bit 8 (A20 level), bit 4 (external-interrupt event enable), bit 3 (IRQ enable), bit 2 (character pending) and bit 0 (emulation enable). Each of these reads back what was written. Bit 8 changes only on a software write.
- R4: A rising edge on ext_irq_kb sets bit 6, and a rising edge on ext_irq_aux sets bit 7, on the third rising clock edge after the line goes high. A line that stays high does not set its flag again.
- R5: Writing 1 to bit 6 or bit 7 clears that flag. Writing 0 leaves it unchanged.
- R6: When bit 4 is 1, an external rising edge raises smi_evt in the same cycle that its flag sets, whatever the value of bit 0. When bit 4 is 0, the edge raises no event.
- R7: irq1 equals bit 3 AND st_out_full AND NOT st_aux_full, and irq12 equals bit 3 AND st_out_full AND st_aux_full. Both are registered, so they follow their inputs one clock later. The two are never high together.
- R8: When bits 0 and 2 are both 1, a falling edge of st_out_full raises smi_evt on the next clock. When bit 2 is 0, that falling edge raises no event.
- R9: When bit 0 is 1, a write of D1h to port 64h sets bit 5 and raises no event. A write of any other value to port 64h clears bit 5 and raises smi_evt.
- R10: When bit 0 is 1 and bit 5 is set, a port 60h write clears bit 5. It raises smi_evt only if data bit 1 differs from bit 8. When bit 5 is clear, every port 60h write raises smi_evt.
- R11: When bit 0 is 0, host I/O writes raise no event and leave bit 5 unchanged.
- R12: Bit 1 reads as bit 2 OR st_in_full OR (bit 4 AND (bit 6 OR bit 7)).
- R13: smi_evt is a single-cycle pulse for each isolated cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_addr | input | 12 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| io_wr | input | 1 | Host I/O write strobe, one cycle per write |
| io_port | input | 16 | Host I/O port number |
| io_data | input | 8 | Host I/O write data |
| ext_irq_kb | input | 1 | Keyboard interrupt from the external controller (asynchronous) |
| ext_irq_aux | input | 1 | Auxiliary interrupt from the external controller (asynchronous) |
| st_out_full | input | 1 | Output-buffer-full status flag |
| st_aux_full | input | 1 | Output data belongs to the auxiliary device |
| st_in_full | input | 1 | Input-buffer-full status flag |
| irq1 | output | 1 | Legacy keyboard interrupt |
| irq12 | output | 1 | Legacy auxiliary interrupt |
| smi_evt | output | 1 | System-management event pulse |

## Verification
The A20 armed flag is visible in the readback and also decides whether the next port 60h write traps. A wrong armed state therefore shows up in two ways: bit 5 reads wrong in the very next cycle, and the event on the following data write is missing or appears when it should not. A wrong edge flag shows at once in bit 1 of the readback, and a missed or repeated edge shows as a wrong event count three cycles after the line moves. Randomized port write sequences are compared cycle by cycle against a bench model of the arm state and the trap decision, and directed cases cover write-1-to-clear and level holding.

// File: rtl/kbd_trap_pkg.sv
package kbd_trap_pkg;
  localparam int REG_W     = 32;
  localparam int CTRL_BITS = 9;

  // bit positions of the control word, decoded by software
  localparam int B_EMU_EN   = 0;
  localparam int B_EMU_INT  = 1;
  localparam int B_CHR_PEND = 2;
  localparam int B_IRQ_EN   = 3;
  localparam int B_EXT_EN   = 4;
  localparam int B_A20_ARM  = 5;
  localparam int B_KB_HIT   = 6;
  localparam int B_AUX_HIT  = 7;
  localparam int B_A20_VAL  = 8;

  typedef struct packed {
    logic a20_val;
    logic aux_hit;
    logic kb_hit;
    logic a20_arm;
    logic ext_en;
    logic irq_en;
    logic chr_pend;
    logic emu_int;
    logic emu_en;
  } ctrl_t;
endpackage

// File: rtl/kbd_trap_rst.sv
module kbd_trap_rst #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/kbd_trap_edge.sv
module kbd_trap_edge #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lines_i,
  output logic [LINES-1:0] rise_o
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [STAGES-1:0] sync_q;
    logic [STAGES-1:0] sync_d;
    logic              prev_q;

    always_comb begin
      sync_d = {sync_q[STAGES-2:0], lines_i[i]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= '0;
        prev_q <= 1'b0;
      end else begin
        sync_q <= sync_d;
        prev_q <= sync_q[STAGES-1];
      end
    end

    assign rise_o[i] = sync_q[STAGES-1] & ~prev_q;
  end
endmodule

// File: rtl/kbd_trap_port.sv
module kbd_trap_port #(
  parameter int          PORT_W    = 16,
  parameter int          BYTE_W    = 8,
  parameter logic [15:0] DATA_PORT = 16'h0060,
  parameter logic [15:0] CMD_PORT  = 16'h0064,
  parameter logic [7:0]  A20_CMD   = 8'hD1,
  parameter int          A20_BIT   = 1
) (
  input  logic              emu_en,
  input  logic              a20_arm,
  input  logic              a20_val,
  input  logic              io_wr,
  input  logic [PORT_W-1:0] io_port,
  input  logic [BYTE_W-1:0] io_data,
  output logic              arm_set,
  output logic              arm_clr,
  output logic              io_trap
);
  logic hit_cmd;
  logic hit_dat;
  logic is_a20_cmd;
  logic a20_differs;

  always_comb begin
    hit_cmd     = io_wr & emu_en & (io_port == PORT_W'(CMD_PORT));
    hit_dat     = io_wr & emu_en & (io_port == PORT_W'(DATA_PORT));
    is_a20_cmd  = (io_data == BYTE_W'(A20_CMD));
    a20_differs = (io_data[A20_BIT] != a20_val);

    arm_set = hit_cmd & is_a20_cmd;
    arm_clr = (hit_cmd & ~is_a20_cmd) | (hit_dat & a20_arm);
    io_trap = (hit_cmd & ~is_a20_cmd)
            | (hit_dat & (~a20_arm | a20_differs));
  end
endmodule

// File: rtl/kbd_trap_regs.sv
module kbd_trap_regs
  import kbd_trap_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sw_we,
  input  logic [CTRL_BITS-1:0] sw_wdata,
  input  logic                 kb_rise,
  input  logic                 aux_rise,
  input  logic                 arm_set,
  input  logic                 arm_clr,
  input  logic                 in_full,
  output ctrl_t                ctrl_o
);
  ctrl_t ctrl_q;
  ctrl_t ctrl_d;
  logic  unused_ro_bits;

  assign unused_ro_bits = sw_wdata[B_A20_ARM] ^ sw_wdata[B_EMU_INT];

  always_comb begin
    ctrl_d = ctrl_q;
    if (sw_we) begin
      ctrl_d.a20_val  = sw_wdata[B_A20_VAL];
      ctrl_d.ext_en   = sw_wdata[B_EXT_EN];
      ctrl_d.irq_en   = sw_wdata[B_IRQ_EN];
      ctrl_d.chr_pend = sw_wdata[B_CHR_PEND];
      ctrl_d.emu_en   = sw_wdata[B_EMU_EN];
      if (sw_wdata[B_KB_HIT]) begin
        ctrl_d.kb_hit = 1'b0;
      end
      if (sw_wdata[B_AUX_HIT]) begin
        ctrl_d.aux_hit = 1'b0;
      end
    end
    // hardware set wins over a same-cycle software clear
    if (kb_rise) begin
      ctrl_d.kb_hit = 1'b1;
    end
    if (aux_rise) begin
      ctrl_d.aux_hit = 1'b1;
    end
    if (arm_set) begin
      ctrl_d.a20_arm = 1'b1;
    end else if (arm_clr) begin
      ctrl_d.a20_arm = 1'b0;
    end
    ctrl_d.emu_int = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
    end
  end

  always_comb begin
    ctrl_o         = ctrl_q;
    ctrl_o.emu_int = ctrl_q.chr_pend | in_full
                   | (ctrl_q.ext_en & (ctrl_q.kb_hit | ctrl_q.aux_hit));
  end
endmodule

// File: rtl/kbd_legacy_trap.sv
module kbd_legacy_trap
  import kbd_trap_pkg::*;
#(
  parameter int          ADDR_W      = 12,
  parameter logic [11:0] CTRL_OFS    = 12'h100,
  parameter int          PORT_W      = 16,
  parameter int          BYTE_W      = 8,
  parameter logic [15:0] DATA_PORT   = 16'h0060,
  parameter logic [15:0] CMD_PORT    = 16'h0064,
  parameter logic [7:0]  A20_CMD     = 8'hD1,
  parameter int          A20_BIT     = 1,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              io_wr,
  input  logic [PORT_W-1:0] io_port,
  input  logic [BYTE_W-1:0] io_data,
  input  logic              ext_irq_kb,
  input  logic              ext_irq_aux,
  input  logic              st_out_full,
  input  logic              st_aux_full,
  input  logic              st_in_full,
  output logic              irq1,
  output logic              irq12,
  output logic              smi_evt
);
  localparam int EXT_LINES = 2;

  logic                 rst_sync_n;
  logic                 sel_ctrl;
  logic                 sw_we;
  logic [EXT_LINES-1:0] ext_rise;
  logic                 kb_rise;
  logic                 aux_rise;
  logic                 arm_set;
  logic                 arm_clr;
  logic                 io_trap;
  ctrl_t                ctrl;
  logic                 of_q;
  logic                 of_fall;
  logic                 evt_d;
  logic                 evt_q;
  logic                 irq1_d;
  logic                 irq1_q;
  logic                 irq12_d;
  logic                 irq12_q;
  logic                 unused_wdata_hi;

  kbd_trap_rst #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  kbd_trap_edge #(.LINES(EXT_LINES), .STAGES(SYNC_STAGES)) u_edge (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .lines_i ({ext_irq_aux, ext_irq_kb}),
    .rise_o  (ext_rise)
  );

  assign kb_rise  = ext_rise[0];
  assign aux_rise = ext_rise[1];

  kbd_trap_port #(
    .PORT_W    (PORT_W),
    .BYTE_W    (BYTE_W),
    .DATA_PORT (DATA_PORT),
    .CMD_PORT  (CMD_PORT),
    .A20_CMD   (A20_CMD),
    .A20_BIT   (A20_BIT)
  ) u_port (
    .emu_en  (ctrl.emu_en),
    .a20_arm (ctrl.a20_arm),
    .a20_val (ctrl.a20_val),
    .io_wr   (io_wr),
    .io_port (io_port),
    .io_data (io_data),
    .arm_set (arm_set),
    .arm_clr (arm_clr),
    .io_trap (io_trap)
  );

  assign sel_ctrl        = (reg_addr == ADDR_W'(CTRL_OFS));
  assign sw_we           = reg_wr & sel_ctrl;
  assign unused_wdata_hi = ^reg_wdata[REG_W-1:CTRL_BITS];

  kbd_trap_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sw_we    (sw_we),
    .sw_wdata (reg_wdata[CTRL_BITS-1:0]),
    .kb_rise  (kb_rise),
    .aux_rise (aux_rise),
    .arm_set  (arm_set),
    .arm_clr  (arm_clr),
    .in_full  (st_in_full),
    .ctrl_o   (ctrl)
  );

  assign reg_rdata = sel_ctrl ? REG_W'(ctrl) : '0;

  // event and interrupt next state
  always_comb begin
    of_fall = of_q & ~st_out_full;
    evt_d   = (ctrl.ext_en & (kb_rise | aux_rise))
            | (ctrl.emu_en & ctrl.chr_pend & of_fall)
            | io_trap;
    irq1_d  = ctrl.irq_en & st_out_full & ~st_aux_full;
    irq12_d = ctrl.irq_en & st_out_full & st_aux_full;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      of_q    <= 1'b0;
      evt_q   <= 1'b0;
      irq1_q  <= 1'b0;
      irq12_q <= 1'b0;
    end else begin
      of_q    <= st_out_full;
      evt_q   <= evt_d;
      irq1_q  <= irq1_d;
      irq12_q <= irq12_d;
    end
  end

  assign smi_evt = evt_q;
  assign irq1    = irq1_q;
  assign irq12   = irq12_q;
endmodule

// File: rtl/kbd_trap_chk.sv
module kbd_trap_chk
  import kbd_trap_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input ctrl_t            ctrl,
  input logic             sw_we,
  input logic             kb_rise,
  input logic             aux_rise,
  input logic             arm_set,
  input logic             of_fall,
  input logic             st_out_full,
  input logic             st_aux_full,
  input logic [REG_W-1:0] reg_rdata,
  input logic             irq1,
  input logic             irq12,
  input logic             smi_evt
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[REG_W-1:CTRL_BITS] == '0); // R2

  AST_A20_SW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_we |=> $stable(ctrl.a20_val)); // R3

  AST_KB_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    kb_rise |=> ctrl.kb_hit); // R4

  AST_AUX_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    aux_rise |=> ctrl.aux_hit); // R4

  AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq1 && irq12)); // R7

  AST_IRQ1_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq1 |-> $past(ctrl.irq_en && st_out_full && !st_aux_full)); // R7

  AST_IRQ12_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq12 |-> $past(ctrl.irq_en && st_out_full && st_aux_full)); // R7

  AST_A20_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    arm_set |=> ctrl.a20_arm); // R9

  AST_A20_CMD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_set && !kb_rise && !aux_rise && !of_fall) |=> !smi_evt); // R9

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.emu_en && !(ctrl.ext_en && (kb_rise || aux_rise))) |=> !smi_evt); // R11
endmodule

bind kbd_legacy_trap kbd_trap_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .ctrl        (ctrl),
  .sw_we       (sw_we),
  .kb_rise     (kb_rise),
  .aux_rise    (aux_rise),
  .arm_set     (arm_set),
  .of_fall     (of_fall),
  .st_out_full (st_out_full),
  .st_aux_full (st_aux_full),
  .reg_rdata   (reg_rdata),
  .irq1        (irq1),
  .irq12       (irq12),
  .smi_evt     (smi_evt)
);

// File: tb/kbd_legacy_trap_test.sv
module kbd_legacy_trap_test;
  logic        clk;
  logic        rst_n;
  logic [11:0] reg_addr;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        io_wr;
  logic [15:0] io_port;
  logic [7:0]  io_data;
  logic        ext_irq_kb;
  logic        ext_irq_aux;
  logic        st_out_full;
  logic        st_aux_full;
  logic        st_in_full;
  logic        irq1;
  logic        irq12;
  logic        smi_evt;

  int  n_chk;
  int  n_bad;
  bit  done;

  kbd_legacy_trap uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr    (reg_addr),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .io_wr       (io_wr),
    .io_port     (io_port),
    .io_data     (io_data),
    .ext_irq_kb  (ext_irq_kb),
    .ext_irq_aux (ext_irq_aux),
    .st_out_full (st_out_full),
    .st_aux_full (st_aux_full),
    .st_in_full  (st_in_full),
    .irq1        (irq1),
    .irq12       (irq12),
    .smi_evt     (smi_evt)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // expected values from the requirements
  function automatic logic [1:0] exp_irq(logic en, logic of, logic aux);
    return {en & of & aux, en & of & ~aux};
  endfunction

  function automatic logic exp_emu_int(logic chr, logic inf, logic ext, logic kb, logic aux);
    return chr | inf | (ext & (kb | aux));
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_ctrl(logic [31:0] v);
    reg_addr  = 12'h100;
    reg_wdata = v;
    reg_wr    = 1'b1;
    step();
    reg_wr    = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic io_put(logic [15:0] p, logic [7:0] d);
    io_port = p;
    io_data = d;
    io_wr   = 1'b1;
    step();
    io_wr   = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] seed;
    logic        arm_m;
    logic        val_m;
    n_chk = 0; n_bad = 0; done = 1'b0;
    seed = $urandom(32'd1357);
    rst_n = 1'b0; reg_addr = 12'h100; reg_wr = 1'b0; reg_wdata = '0;
    io_wr = 1'b0; io_port = '0; io_data = '0;
    ext_irq_kb = 1'b0; ext_irq_aux = 1'b0;
    st_out_full = 1'b0; st_aux_full = 1'b0; st_in_full = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(4);

    // R1 reset state
    rd(12'h100, v);
    check("R1 ctrl", v, 32'h0);
    check("R1 outs", {29'd0, irq1, irq12, smi_evt}, 32'h0);

    // R2 R3 write all ones
    wr_ctrl(32'hFFFF_FFFF);
    rd(12'h100, v);
    check("R3 R2 all ones", v, 32'h0000_011F);
    rd(12'h104, v);
    check("R2 other offset", v, 32'h0);
    wr_ctrl(32'h0);
    rd(12'h100, v);
    check("R3 cleared", v, 32'h0);

    // R4 R6 R13 keyboard edge with event enable, emulation off
    wr_ctrl(32'h10);
    ext_irq_kb = 1'b1;
    step(2);
    check("R4 no early event", {31'd0, smi_evt}, 32'h0);
    step();
    check("R6 edge event", {31'd0, smi_evt}, 32'h1);
    rd(12'h100, v);
    check("R4 kb flag R12", v, 32'h52);
    step();
    check("R13 one cycle", {31'd0, smi_evt}, 32'h0);
    // R5 clear while level still high, no retrigger
    wr_ctrl(32'h50);
    step(4);
    rd(12'h100, v);
    check("R5 R4 cleared held", v, 32'h10);
    // aux edge, then write 0 leaves flag
    ext_irq_aux = 1'b1;
    step(3);
    check("R6 aux event", {31'd0, smi_evt}, 32'h1);
    wr_ctrl(32'h10);
    rd(12'h100, v);
    check("R5 zero no effect", v, 32'h92);
    wr_ctrl(32'h90);
    rd(12'h100, v);
    check("R5 aux cleared", v, 32'h10);
    ext_irq_kb = 1'b0; ext_irq_aux = 1'b0;
    wr_ctrl(32'h0);
    step(3);
    // R6 disabled: flag but no event
    ext_irq_kb = 1'b1;
    v = '0;
    for (int i = 0; i < 5; i++) begin
      step();
      if (smi_evt) v = 32'h1;
    end
    check("R6 no event when disabled", v, 32'h0);
    rd(12'h100, v);
    check("R4 flag without event", v, 32'h40);
    wr_ctrl(32'h40);
    ext_irq_kb = 1'b0;
    step(3);

    // R7 random steering
    for (int i = 0; i < 40; i++) begin
      logic en;
      en = 1'($urandom);
      wr_ctrl({28'd0, en, 3'd0});
      st_out_full = 1'($urandom);
      st_aux_full = 1'($urandom);
      step();
      check("R7 irq steering", {30'd0, irq12, irq1},
            {30'd0, exp_irq(en, st_out_full, st_aux_full)});
    end
    st_out_full = 1'b0; st_aux_full = 1'b0;
    wr_ctrl(32'h0);

    // R8 character pending
    wr_ctrl(32'h05);
    st_out_full = 1'b1; step();
    st_out_full = 1'b0; step();
    check("R8 fall event", {31'd0, smi_evt}, 32'h1);
    step();
    check("R13 fall pulse ends", {31'd0, smi_evt}, 32'h0);
    wr_ctrl(32'h01);
    st_out_full = 1'b1; step();
    st_out_full = 1'b0; step();
    check("R8 no pending no event", {31'd0, smi_evt}, 32'h0);

    // R12 random emulation-interrupt readback
    for (int i = 0; i < 20; i++) begin
      logic chr;
      logic ext;
      chr = 1'($urandom);
      ext = 1'($urandom);
      wr_ctrl({27'd0, ext, 1'b0, chr, 2'b00});
      st_in_full = 1'($urandom);
      rd(12'h100, v);
      check("R12 emu int", {31'd0, v[1]},
            {31'd0, exp_emu_int(chr, st_in_full, ext, 1'b0, 1'b0)});
    end
    st_in_full = 1'b0;

    // R9 R10 directed A20 sequence
    wr_ctrl(32'h101);
    io_put(16'h0064, 8'hD1);
    rd(12'h100, v);
    check("R9 armed", {31'd0, v[5]}, 32'h1);
    check("R9 no event", {31'd0, smi_evt}, 32'h0);
    io_put(16'h0060, 8'h02);
    check("R10 match absorbed", {31'd0, smi_evt}, 32'h0);
    rd(12'h100, v);
    check("R10 arm cleared", {31'd0, v[5]}, 32'h0);
    io_put(16'h0064, 8'hD1);
    io_put(16'h0060, 8'h00);
    check("R10 mismatch event", {31'd0, smi_evt}, 32'h1);

    // R9 R10 random port traffic against a model
    arm_m = 1'b0;
    val_m = 1'b1;
    for (int i = 0; i < 300; i++) begin
      logic [15:0] p;
      logic [7:0]  d;
      logic        exp_e;
      int          pick;
      if ($urandom % 8 == 0) begin
        val_m = 1'($urandom);
        wr_ctrl({23'd0, val_m, 8'h01});
      end
      pick = $urandom % 5;
      p = (pick < 2) ? 16'h0064 : (pick < 4) ? 16'h0060 : 16'h0070;
      d = ($urandom % 3 == 0) ? 8'hD1 : 8'($urandom);
      exp_e = 1'b0;
      if (p == 16'h0064) begin
        exp_e = (d != 8'hD1);
        arm_m = (d == 8'hD1);
      end else if (p == 16'h0060) begin
        exp_e = !arm_m || (d[1] != val_m);
        arm_m = 1'b0;
      end
      io_put(p, d);
      check("R10 R9 trap", {31'd0, smi_evt}, {31'd0, exp_e});
      rd(12'h100, v);
      check("R9 R10 arm state", {31'd0, v[5]}, {31'd0, arm_m});
    end

    // R11 emulation off ignores port writes
    wr_ctrl(32'h01);
    io_put(16'h0064, 8'hD1);
    wr_ctrl(32'h00);
    io_put(16'h0064, 8'h00);
    check("R11 no event cmd", {31'd0, smi_evt}, 32'h0);
    io_put(16'h0060, 8'h00);
    check("R11 no event data", {31'd0, smi_evt}, 32'h0);
    rd(12'h100, v);
    check("R11 arm kept R2", v, 32'h20);
    wr_ctrl(32'h20);
    rd(12'h100, v);
    check("R2 arm not sw writable", v, 32'h20);

    step(2);
    finish_run();
  end
endmodule